// File: doc/BRIEF.md
# Atomic Semaphore Operation Unit

This block keeps a bank of signed semaphore counters and runs two indivisible read-modify-write operations on them for several requesting ports. A counter of minus one marks a free resource. Zero marks a resource in use with no one queued. A positive value n marks a resource in use with n processes queued. A requester either claims a resource with increment-and-test or gives it back with test-and-decrement. It gets a two-bit condition code in return. On a claim the code says whether the resource was granted. On a release it says whether other processes are still queued.

Each port has a valid/ready request channel that carries an operation select and a semaphore index. It also has a one-cycle response strobe that carries the condition code and an overflow flag. All ports share one update path, and a round-robin arbiter lets exactly one operation through per cycle. Each update therefore completes in a single edge and can never interleave with another update, even when the requests address different semaphores.

Top module: `sem_unit`

## Requirements
- R1: After reset every counter holds -1 (free), no `req_ready` bit is high while its `req_valid` is low, and every `rsp_valid` bit is low.
- R2: Increment-and-test (`req_op` = 0) adds one to the addressed counter and reports the code of the new value: 00 means the resource was granted, 01 means the requester was only added to the waiting count.
- R3: Test-and-decrement (`req_op` = 1) reports the code of the counter value before the update and then subtracts one. A code of 01 tells the releasing process that others are waiting.
- R4: The condition code is 00 for zero, 01 for positive and 10 for negative. The value 11 never appears on a response.
- R5: A request accepted on port p (valid and ready high at a rising edge) produces `rsp_valid[p]` high for exactly the following cycle, with its code and flag. No response appears without an acceptance.
- R6: At most one `req_ready` bit is high in any cycle, and a ready bit is high only while its own valid bit is high.
- R7: When several ports request in the same cycle, the grant goes to the first requesting port at or after a rotating pointer. The pointer then moves to the port after the one just served. This applies even when the ports address different semaphores.
- R8: An increment-and-test on a counter already at the largest positive value leaves the counter unchanged, reports code 01 and raises `rsp_ovf`. Every other operation reports `rsp_ovf` low.
- R9: An operation changes only the counter it addresses.
- R10: Operations are indivisible. When two requests on one semaphore contend, the one served second sees the counter as left by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORT | Request present, one bit per port |
| req_ready | output | NPORT | Request accepted this cycle, one bit per port |
| req_op | input | NPORT | Operation per port: 0 increment-and-test, 1 test-and-decrement |
| req_idx | input | NPORT*IDX_W | Semaphore index per port, port p in bits [p*IDX_W +: IDX_W] |
| rsp_valid | output | NPORT | Response strobe per port |
| rsp_cc | output | 2*NPORT | Condition code per port, port p in bits [2p +: 2] |
| rsp_ovf | output | NPORT | Saturation flag per port |

## Verification
A counter that holds a wrong value is not seen at once. It shows up on the next operation that addresses that semaphore, as a wrong condition code one cycle after acceptance, so the bench reads every counter back through later claims and releases. A fault in the arbiter pointer shows up in the same cycle as a ready bit on the wrong port during contention. A lost or misplaced update shows up as a wrong code on the contending loser one cycle later. Saturation faults only show up after the counter has been driven to its ceiling, so the bench pushes it there and then probes one step below and one step above.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      CC_ZERO = 2'b00,
      CC_POS  = 2'b01,
      CC_NEG  = 2'b10
   } sem_cc_e;

   typedef enum logic {
      OP_INC_TEST = 1'b0,
      OP_TEST_DEC = 1'b1
   } sem_op_e;
endpackage

// File: rtl/sem_rr_arb.sv
module sem_rr_arb #(
   parameter int NPORT = 2,
   localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NPORT-1:0] req,
   output logic [NPORT-1:0] gnt,
   output logic [PW-1:0]    gnt_id,
   output logic             gnt_any
);
   logic [PW-1:0] ptr_q;

   always_comb begin
      gnt     = '0;
      gnt_id  = '0;
      gnt_any = 1'b0;
      for (int k = 0; k < NPORT; k++) begin
         int c;
         c = int'(ptr_q) + k;
         if (c >= NPORT) c = c - NPORT;
         if (!gnt_any && req[c]) begin
            gnt[c]  = 1'b1;
            gnt_id  = PW'(c);
            gnt_any = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= '0;
      end else if (gnt_any) begin
         if (int'(gnt_id) == NPORT - 1) ptr_q <= '0;
         else                            ptr_q <= gnt_id + PW'(1);
      end
   end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM = 16,
   parameter int CNT_W   = 16,
   localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic signed [CNT_W-1:0] rd_val,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic signed [CNT_W-1:0] wr_val
);
   logic signed [CNT_W-1:0] cnt_q [NUM_SEM];

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (rst)                                  cnt_q[g] <= '1;
         else if (wr_en && wr_idx == IDX_W'(g))    cnt_q[g] <= wr_val;
      end
   end

   always_comb begin
      rd_val = '1;
      for (int i = 0; i < NUM_SEM; i++)
         if (rd_idx == IDX_W'(i)) rd_val = cnt_q[i];
   end
endmodule

// File: rtl/sem_alu.sv
module sem_alu
   import sem_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  sem_op_e                 op,
   input  logic signed [CNT_W-1:0] cur,
   output logic signed [CNT_W-1:0] nxt,
   output sem_cc_e                 cc,
   output logic                    ovf
);
   localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};

   function automatic sem_cc_e code_of(logic signed [CNT_W-1:0] v);
      if (v == '0)      return CC_ZERO;
      else if (v[CNT_W-1]) return CC_NEG;
      else              return CC_POS;
   endfunction

   always_comb begin
      ovf = 1'b0;
      if (op == OP_INC_TEST) begin
         if (cur == CMAX) begin
            nxt = CMAX;
            ovf = 1'b1;
         end else begin
            nxt = cur + CNT_W'(1);
         end
         cc = code_of(nxt);
      end else begin
         nxt = cur - CNT_W'(1);
         cc  = code_of(cur);
      end
   end
endmodule

// File: rtl/sem_unit.sv
module sem_unit
   import sem_pkg::*;
#(
   parameter int NPORT   = 2,
   parameter int NUM_SEM = 16,
   parameter int CNT_W   = 16,
   localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1,
   localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NPORT-1:0]       req_valid,
   output logic [NPORT-1:0]       req_ready,
   input  logic [NPORT-1:0]       req_op,
   input  logic [NPORT*IDX_W-1:0] req_idx,
   output logic [NPORT-1:0]       rsp_valid,
   output logic [2*NPORT-1:0]     rsp_cc,
   output logic [NPORT-1:0]       rsp_ovf
);
   if (NPORT < 1)   $error("sem_unit: NPORT must be at least 1");
   if (NUM_SEM < 1) $error("sem_unit: NUM_SEM must be at least 1");
   if (CNT_W < 3)   $error("sem_unit: CNT_W must be at least 3");

   logic [NPORT-1:0]        gnt;
   logic [PW-1:0]           gnt_id;
   logic                    gnt_any;
   logic [IDX_W-1:0]        sel_idx;
   sem_op_e                 sel_op;
   logic signed [CNT_W-1:0] cur_val, nxt_val;
   sem_cc_e                 cc_new;
   logic                    ovf_new;

   sem_rr_arb #(.NPORT(NPORT)) u_arb (
      .clk(clk), .rst(rst), .req(req_valid),
      .gnt(gnt), .gnt_id(gnt_id), .gnt_any(gnt_any)
   );

   always_comb begin
      sel_idx = '0;
      sel_op  = OP_INC_TEST;
      for (int p = 0; p < NPORT; p++) begin
         if (gnt_id == PW'(p)) begin
            sel_idx = req_idx[p*IDX_W +: IDX_W];
            sel_op  = sem_op_e'(req_op[p]);
         end
      end
   end

   sem_bank #(.NUM_SEM(NUM_SEM), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst(rst),
      .rd_idx(sel_idx), .rd_val(cur_val),
      .wr_en(gnt_any), .wr_idx(sel_idx), .wr_val(nxt_val)
   );

   sem_alu #(.CNT_W(CNT_W)) u_alu (
      .op(sel_op), .cur(cur_val), .nxt(nxt_val), .cc(cc_new), .ovf(ovf_new)
   );

   assign req_ready = gnt;

   for (genvar p = 0; p < NPORT; p++) begin : g_rsp
      always_ff @(posedge clk) begin
         if (rst) begin
            rsp_valid[p]      <= 1'b0;
            rsp_cc[2*p +: 2]  <= CC_ZERO;
            rsp_ovf[p]        <= 1'b0;
         end else begin
            rsp_valid[p] <= gnt[p];
            if (gnt[p]) begin
               rsp_cc[2*p +: 2] <= cc_new;
               rsp_ovf[p]       <= ovf_new;
            end
         end
      end
   end
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
   parameter int NPORT = 2,
   parameter int IDX_W = 4
) (
   input logic                   clk,
   input logic                   rst,
   input logic [NPORT-1:0]       req_valid,
   input logic [NPORT-1:0]       req_ready,
   input logic [NPORT-1:0]       rsp_valid,
   input logic [2*NPORT-1:0]     rsp_cc,
   input logic [NPORT-1:0]       rsp_ovf
);
   // R6
   single_grant_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_ready));

   // R6
   ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (req_ready & ~req_valid) == '0);

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      // R5
      rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
         (req_valid[p] && req_ready[p]) |=> rsp_valid[p]);

      // R5
      no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
         !(req_valid[p] && req_ready[p]) |=> !rsp_valid[p]);

      // R4
      cc_legal_chk: assert property (@(posedge clk) disable iff (rst)
         rsp_valid[p] |-> (rsp_cc[2*p +: 2] != 2'b11));

      // R8
      ovf_means_positive_chk: assert property (@(posedge clk) disable iff (rst)
         (rsp_valid[p] && rsp_ovf[p]) |-> (rsp_cc[2*p +: 2] == 2'b01));
   end

   if (NPORT == 2) begin : g_two
      // R7
      rr_alternate_chk: assert property (@(posedge clk) disable iff (rst)
         (req_valid == 2'b11 && req_ready[0]) |=> (req_valid == 2'b11) |-> req_ready[1]);

      // R7
      rr_alternate_back_chk: assert property (@(posedge clk) disable iff (rst)
         (req_valid == 2'b11 && req_ready[1]) |=> (req_valid == 2'b11) |-> req_ready[0]);
   end
endmodule

bind sem_unit sem_unit_chk #(.NPORT(NPORT), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_cc(rsp_cc), .rsp_ovf(rsp_ovf)
);

// File: tb/tb_sem_unit.sv
`timescale 1ns/1ps
module tb_sem_unit;
   localparam int NP    = 2;
   localparam int NS    = 16;
   localparam int CW    = 16;
   localparam int IW    = 4;
   localparam int CMAX  = (1 << (CW-1)) - 1;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NP-1:0]   req_valid = '0;
   logic [NP-1:0]   req_ready;
   logic [NP-1:0]   req_op = '0;
   logic [NP*IW-1:0] req_idx = '0;
   logic [NP-1:0]   rsp_valid;
   logic [2*NP-1:0] rsp_cc;
   logic [NP-1:0]   rsp_ovf;

   int vecs = 0;
   int errs = 0;
   int mdl [NS];
   int rr = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sem_unit #(.NPORT(NP), .NUM_SEM(NS), .CNT_W(CW)) dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_idx(req_idx), .rsp_valid(rsp_valid),
      .rsp_cc(rsp_cc), .rsp_ovf(rsp_ovf)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int code(input int v);
      if (v == 0) return 0;
      if (v > 0)  return 1;
      return 2;
   endfunction

   // model update, returns expected {ovf, cc}
   function automatic int model_op(input int op, input int idx);
      int c;
      if (op == 0) begin
         if (mdl[idx] == CMAX) return 4 | 1;
         mdl[idx]++;
         return code(mdl[idx]);
      end
      c = code(mdl[idx]);
      mdl[idx]--;
      return c;
   endfunction

   task automatic op1(input int p, input int op, input int idx, input string tag);
      int e;
      @(negedge clk);
      req_valid[p] = 1'b1;
      req_op[p] = op[0];
      req_idx[p*IW +: IW] = IW'(idx);
      #0.1;
      chk(req_ready == NP'(1 << p), {tag, " R6 ready"}, int'(req_ready), 1 << p);
      e = model_op(op, idx);
      rr = (p + 1) % NP;
      @(negedge clk);
      req_valid[p] = 1'b0;
      chk(rsp_valid == NP'(1 << p), {tag, " R5 rsp_valid"}, int'(rsp_valid), 1 << p);
      chk(int'(rsp_cc[2*p +: 2]) == (e & 3), {tag, " cc"}, int'(rsp_cc[2*p +: 2]), e & 3);
      chk(int'(rsp_ovf[p]) == (e >> 2), {tag, " R8 ovf"}, int'(rsp_ovf[p]), e >> 2);
      @(negedge clk);
      chk(rsp_valid == '0, {tag, " R5 single pulse"}, int'(rsp_valid), 0);
   endtask

   task automatic contend(input int op0, input int idx0, input int op1v, input int idx1,
                          input string tag);
      int w, l, ew, el;
      int ops[2];
      int ids[2];
      ops[0] = op0; ops[1] = op1v; ids[0] = idx0; ids[1] = idx1;
      w = rr; l = 1 - rr;
      @(negedge clk);
      req_valid = 2'b11;
      req_op = {op1v[0], op0[0]};
      req_idx = {IW'(idx1), IW'(idx0)};
      #0.1;
      chk(req_ready == NP'(1 << w), {tag, " R7 winner"}, int'(req_ready), 1 << w);
      ew = model_op(ops[w], ids[w]);
      el = model_op(ops[l], ids[l]);
      @(negedge clk);
      chk(rsp_valid == NP'(1 << w), {tag, " R5 winner rsp"}, int'(rsp_valid), 1 << w);
      chk(int'(rsp_cc[2*w +: 2]) == (ew & 3), {tag, " winner cc"}, int'(rsp_cc[2*w +: 2]), ew & 3);
      chk(req_ready == NP'(1 << l), {tag, " R7 loser next"}, int'(req_ready), 1 << l);
      req_valid[w] = 1'b0;
      @(negedge clk);
      req_valid[l] = 1'b0;
      chk(rsp_valid == NP'(1 << l), {tag, " R5 loser rsp"}, int'(rsp_valid), 1 << l);
      chk(int'(rsp_cc[2*l +: 2]) == (el & 3), {tag, " R10 loser cc"}, int'(rsp_cc[2*l +: 2]), el & 3);
      rr = w;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready == '0, "R1 ready idle", int'(req_ready), 0);
      chk(rsp_valid == '0, "R1 rsp idle", int'(rsp_valid), 0);
      op1(0, 0, 3, "R1 free after reset");
      op1(1, 1, 3, "R1 release");
   endtask

   task automatic t_claim_release();
      op1(0, 0, 7, "R2 grant");
      op1(1, 0, 7, "R2 queued one");
      op1(0, 0, 7, "R2 queued two");
      op1(1, 1, 7, "R3 release waiting");
      op1(0, 1, 7, "R3 release last waiter");
      op1(1, 1, 7, "R3 release free");
      op1(0, 1, 7, "R4 negative code");
      op1(1, 0, 7, "R4 back to free");
      op1(0, 0, 7, "R2 grant again");
   endtask

   task automatic t_independent();
      op1(0, 0, 9, "R9 grant 9");
      op1(1, 0, 10, "R9 neighbour 10 free");
      op1(0, 0, 8, "R9 neighbour 8 free");
      op1(1, 1, 9, "R9 release 9");
   endtask

   task automatic t_contend();
      contend(0, 12, 0, 12, "R10 same sem");
      contend(1, 12, 1, 12, "R10 same sem release");
      contend(0, 1, 0, 2, "R7 different sems");
      contend(0, 1, 1, 2, "R7 mixed ops");
   endtask

   task automatic t_saturate();
      int steps;
      steps = CMAX - mdl[15];
      @(negedge clk);
      req_valid[0] = 1'b1;
      req_op[0] = 1'b0;
      req_idx[0 +: IW] = IW'(15);
      repeat (steps) @(negedge clk);
      req_valid[0] = 1'b0;
      mdl[15] = CMAX;
      rr = 1;
      @(negedge clk);
      op1(0, 0, 15, "R8 saturate");
      op1(0, 1, 15, "R8 step below ceiling");
      op1(0, 0, 15, "R8 back to ceiling");
      op1(0, 0, 15, "R8 saturate again");
   endtask

   initial begin
      for (int i = 0; i < NS; i++) mdl[i] = -1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_claim_release();
      t_independent();
      t_contend();
      t_saturate();
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (150000) @(posedge clk);
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule